// File: doc/BRIEF.md
# LCD Module DMA Controller

This block moves a run of 16-bit words between an on-chip synchronous memory and the parallel bus of an LCD module, so the CPU does not have to copy them itself. Software sets a start address and a word count, then writes one of four trigger bits. The triggers select send command, send data, read command or read data. Send modes fetch each word from memory and put it on the LCD bus with one write strobe. Read modes strobe the LCD bus, sample the returned word and store it in memory. A command/data select line tells the module which kind of word is moving.

When the last word is done, a sticky completion flag is set. An interrupt is raised when that flag is set and interrupts are enabled. The CPU can reach the 16-bit word register as a low byte and a high byte. A CPU write to either byte during a transfer aborts the transfer and sets a sticky overwrite flag. Two 2-bit priority fields are kept for the system's arbiter and interrupt controller. They are driven on pins and do nothing inside the block.

Register map (3-bit index, 8-bit data):
- 0 config: bit 0 interrupt enable, bits 2:1 interrupt priority, bits 4:3 bus priority.
- 1 control: bit 0 enable. Bits 1, 2, 3 and 4 are the triggers for send command, send data, read command and read data.
- 2 status: bit 0 done, bit 1 overwrite, bit 2 busy (read only).
- 3 start address.
- 4 count (words − 1).
- 5 word low byte.
- 6 word high byte.

Top module: `lcd_dma_ctrl`

## Requirements
- R1: A control write whose bit 0 is 0 starts no transfer, whatever trigger bits it carries. Bit 0 of control is the enable and is stored from every control write.
- R2: Trigger bit 1 selects send command, bit 2 send data, bit 3 read command and bit 4 read data. When several are set, the lowest-numbered bit wins. `lcd_dc` is 0 in command modes and 1 in data modes.
- R3: Trigger bits written as 0 start nothing. A control write of 0x01 leaves the block idle.
- R4: A send transfer of count C puts memory words `start`..`start+C` on `lcd_dout` in address order, with one `lcd_wr` cycle per word. It takes 3 cycles per word, and the done flag is set at the 3(C+1)-th clock edge after the trigger edge.
- R5: A read transfer of count C pulses `lcd_rd` once per word. It stores the `lcd_din` value sampled during that pulse at addresses `start`..`start+C`. It takes 2 cycles per word, and the done flag is set at the 2(C+1)-th edge.
- R6: On completion, status bit 0 (done) is set and busy clears. Done stays set until software writes status with bit 0 at 0. Writing it as 1 leaves done unchanged.
- R7: `irq` is 1 exactly when done is set and config bit 0 is 1.
- R8: A write to the word low or high byte while busy stops the transfer from the next cycle: no further strobe or memory access, busy clears, done is not set, and status bit 1 (overwrite) is set. The written byte is stored and readable.
- R9: The overwrite flag is cleared only by a status write with bit 1 at 0. A word-byte write while idle does not set it.
- R10: A trigger written while busy is ignored. The running transfer keeps its mode, length and timing.
- R11: The priority fields read back from config and appear on `irq_prio` and `bus_prio`.
- R12: `lcd_wr` and `lcd_rd` are never 1 together, and neither are `mem_rd` and `mem_wr`. All four are 0 while idle, and status bit 2 shows busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| mem_addr | output | MEM_AW | Memory word address |
| mem_rd | output | 1 | Memory read request; data due next cycle |
| mem_rdata | input | 16 | Memory read data |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| lcd_dc | output | 1 | 0 command, 1 data |
| lcd_wr | output | 1 | LCD write strobe |
| lcd_rd | output | 1 | LCD read strobe |
| lcd_dout | output | 16 | LCD bus data out |
| lcd_din | input | 16 | LCD bus data in, sampled at the end of the read strobe |
| irq | output | 1 | Completion interrupt |
| irq_prio | output | 2 | Stored interrupt priority |
| bus_prio | output | 2 | Stored bus-access priority |

## Verification
Each register write takes effect at the clock edge on which `reg_wr` is sampled. Busy, the flags, `irq` and the abort are therefore visible in the cycle that follows that edge. Done is due 3(C+1) edges after a send trigger and 2(C+1) edges after a read trigger. The bench drives and samples on falling edges and counts whole cycles from the trigger edge. It checks that busy is still set one cycle before the due edge and that done is set just after it. Strobes and memory writes are logged at rising edges, so word order, count and the command/data select are compared after the transfer, and no pulse may follow an abort.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 8;
    localparam int LCD_DW = 16;

    localparam logic [REG_AW-1:0] RA_CFG  = 3'd0;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd2;
    localparam logic [REG_AW-1:0] RA_ADDR = 3'd3;
    localparam logic [REG_AW-1:0] RA_CNT  = 3'd4;
    localparam logic [REG_AW-1:0] RA_DLO  = 3'd5;
    localparam logic [REG_AW-1:0] RA_DHI  = 3'd6;

    // mode bit 0: data (1) / command (0); mode bit 1: read (1) / send (0)
    typedef enum logic [1:0] {
        M_SEND_CMD = 2'd0,
        M_SEND_DAT = 2'd1,
        M_READ_CMD = 2'd2,
        M_READ_DAT = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_LOAD  = 3'd2,
        S_WSTB  = 3'd3,
        S_RSTB  = 3'd4,
        S_STORE = 3'd5
    } state_e;
endpackage

// File: rtl/lcd_dma_regs.sv
module lcd_dma_regs
    import lcd_dma_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_DW-1:0]   wdata,
    input  logic                busy,
    input  logic                done_set,
    output logic                irq_en,
    output logic [1:0]          irq_prio,
    output logic [1:0]          bus_prio,
    output logic                enable,
    output logic [MEM_AW-1:0]   base_addr,
    output logic [CNT_W-1:0]    word_cnt,
    output logic                done_flag,
    output logic                ovw_flag,
    output logic                start,
    output mode_e               start_mode
);
    localparam int NUM_TRIG = 4;

    typedef struct packed {
        logic              irq_en;
        logic [1:0]        ip;
        logic [1:0]        bp;
        logic              en;
        logic [MEM_AW-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              ovw;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_TRIG-1:0] trig;
    logic                data_wr;

    always_comb begin
        r_d        = r_q;
        start      = 1'b0;
        start_mode = M_SEND_CMD;
        trig       = wdata[NUM_TRIG:1];
        data_wr    = wr && (addr == RA_DLO || addr == RA_DHI);
        // lowest-numbered trigger wins
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (trig[i]) start_mode = mode_e'(2'(i));
        end
        if (wr) begin
            case (addr)
                RA_CFG: begin
                    r_d.irq_en = wdata[0];
                    r_d.ip     = wdata[2:1];
                    r_d.bp     = wdata[4:3];
                end
                RA_CTRL: begin
                    r_d.en = wdata[0];
                    start  = wdata[0] && !busy && (|trig);
                end
                RA_STAT: begin
                    if (!wdata[0]) r_d.done = 1'b0;
                    if (!wdata[1]) r_d.ovw  = 1'b0;
                end
                RA_ADDR: r_d.addr = MEM_AW'(wdata);
                RA_CNT:  r_d.cnt  = CNT_W'(wdata);
                default: ;
            endcase
        end
        if (done_set)        r_d.done = 1'b1;
        if (data_wr && busy) r_d.ovw  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_en    = r_q.irq_en;
    assign irq_prio  = r_q.ip;
    assign bus_prio  = r_q.bp;
    assign enable    = r_q.en;
    assign base_addr = r_q.addr;
    assign word_cnt  = r_q.cnt;
    assign done_flag = r_q.done;
    assign ovw_flag  = r_q.ovw;
endmodule

// File: rtl/lcd_dma_seq.sv
module lcd_dma_seq
    import lcd_dma_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mode_e             start_mode,
    input  logic [MEM_AW-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              cpu_wr_lo,
    input  logic              cpu_wr_hi,
    input  logic [REG_DW-1:0] cpu_byte,
    input  logic [LCD_DW-1:0] mem_rdata,
    input  logic [LCD_DW-1:0] lcd_din,
    output logic              busy,
    output logic              done_set,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [LCD_DW-1:0] mem_wdata,
    output logic              lcd_dc,
    output logic              lcd_wr,
    output logic              lcd_rd,
    output logic [LCD_DW-1:0] lcd_dout,
    output logic [LCD_DW-1:0] hold_word
);
    typedef struct packed {
        state_e            st;
        mode_e             mode;
        logic [MEM_AW-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [LCD_DW-1:0] hold;
    } seq_t;

    seq_t s_d, s_q;
    logic last;
    logic abort;

    always_comb begin
        s_d      = s_q;
        done_set = 1'b0;
        last     = (s_q.cnt == '0);
        abort    = (cpu_wr_lo || cpu_wr_hi) && (s_q.st != S_IDLE);
        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.mode = start_mode;
                    s_d.addr = base_addr;
                    s_d.cnt  = word_cnt;
                    s_d.st   = start_mode[1] ? S_RSTB : S_FETCH;
                end
            end
            S_FETCH: s_d.st = S_LOAD;
            S_LOAD: begin
                s_d.hold = mem_rdata;
                s_d.st   = S_WSTB;
            end
            S_RSTB: begin
                s_d.hold = lcd_din;
                s_d.st   = S_STORE;
            end
            S_WSTB, S_STORE: begin
                if (last) begin
                    s_d.st   = S_IDLE;
                    done_set = 1'b1;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                    s_d.cnt  = s_q.cnt - 1'b1;
                    s_d.st   = (s_q.st == S_WSTB) ? S_FETCH : S_RSTB;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
        if (abort) begin
            s_d.st   = S_IDLE;
            done_set = 1'b0;
        end
        if (cpu_wr_lo) s_d.hold[7:0]        = cpu_byte;
        if (cpu_wr_hi) s_d.hold[LCD_DW-1:8] = cpu_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != S_IDLE);
    assign mem_addr  = s_q.addr;
    assign mem_rd    = (s_q.st == S_FETCH);
    assign mem_wr    = (s_q.st == S_STORE);
    assign mem_wdata = s_q.hold;
    assign lcd_dc    = s_q.mode[0];
    assign lcd_wr    = (s_q.st == S_WSTB);
    assign lcd_rd    = (s_q.st == S_RSTB);
    assign lcd_dout  = s_q.hold;
    assign hold_word = s_q.hold;
endmodule

// File: rtl/lcd_dma_ctrl.sv
module lcd_dma_ctrl
    import lcd_dma_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [15:0]       mem_rdata,
    output logic              mem_wr,
    output logic [15:0]       mem_wdata,
    output logic              lcd_dc,
    output logic              lcd_wr,
    output logic              lcd_rd,
    output logic [15:0]       lcd_dout,
    input  logic [15:0]       lcd_din,
    output logic              irq,
    output logic [1:0]        irq_prio,
    output logic [1:0]        bus_prio
);
    logic              busy, done_set, done_flag, ovw_flag;
    logic              irq_en, enable, start;
    mode_e             start_mode;
    logic [MEM_AW-1:0] base_addr;
    logic [CNT_W-1:0]  word_cnt;
    logic [15:0]       hold_word;
    logic              cpu_wr_lo, cpu_wr_hi;

    assign cpu_wr_lo = reg_wr && (reg_addr == RA_DLO);
    assign cpu_wr_hi = reg_wr && (reg_addr == RA_DHI);

    lcd_dma_regs #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .done_set(done_set), .irq_en(irq_en), .irq_prio(irq_prio),
        .bus_prio(bus_prio), .enable(enable), .base_addr(base_addr),
        .word_cnt(word_cnt), .done_flag(done_flag), .ovw_flag(ovw_flag),
        .start(start), .start_mode(start_mode)
    );

    lcd_dma_seq #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .base_addr(base_addr), .word_cnt(word_cnt), .cpu_wr_lo(cpu_wr_lo),
        .cpu_wr_hi(cpu_wr_hi), .cpu_byte(reg_wdata), .mem_rdata(mem_rdata),
        .lcd_din(lcd_din), .busy(busy), .done_set(done_set), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .lcd_dc(lcd_dc),
        .lcd_wr(lcd_wr), .lcd_rd(lcd_rd), .lcd_dout(lcd_dout), .hold_word(hold_word)
    );

    assign irq = done_flag && irq_en;

    always_comb begin
        case (reg_addr)
            RA_CFG:  reg_rdata = {3'b000, bus_prio, irq_prio, irq_en};
            RA_CTRL: reg_rdata = {7'd0, enable};
            RA_STAT: reg_rdata = {5'd0, busy, ovw_flag, done_flag};
            RA_ADDR: reg_rdata = 8'(base_addr);
            RA_CNT:  reg_rdata = 8'(word_cnt);
            RA_DLO:  reg_rdata = hold_word[7:0];
            RA_DHI:  reg_rdata = hold_word[15:8];
            default: reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/lcd_dma_chk.sv
module lcd_dma_chk
    import lcd_dma_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       lcd_wr,
    input logic       lcd_rd,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       irq,
    input logic       busy,
    input logic       done_flag,
    input logic       ovw_flag
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_wr && lcd_rd)); // R12
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R12
    AST_ACTIVITY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_wr || lcd_rd || mem_rd || mem_wr) |-> busy); // R12
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && reg_addr == RA_CTRL && !reg_wdata[0]) |=> !busy); // R1
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy)); // R6
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag); // R7
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == RA_DLO || reg_addr == RA_DHI))
        |=> (!busy && ovw_flag && !$rose(done_flag))); // R8
    AST_OVW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovw_flag && !(reg_wr && reg_addr == RA_STAT && !reg_wdata[1])) |=> ovw_flag); // R9
endmodule

bind lcd_dma_ctrl lcd_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lcd_wr(lcd_wr), .lcd_rd(lcd_rd), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .irq(irq), .busy(busy), .done_flag(done_flag),
    .ovw_flag(ovw_flag)
);

// File: tb/tb_lcd_dma_ctrl.sv
module tb_lcd_dma_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata = 16'd0;
    logic [15:0] mem_wdata;
    logic        lcd_dc, lcd_wr, lcd_rd;
    logic [15:0] lcd_dout, lcd_din;
    logic        irq;
    logic [1:0]  irq_prio, bus_prio;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] mem [256];
    logic [15:0] wlog [64];
    logic        wdc  [64];
    int          wn = 0;
    int          rd_cnt = 0;
    int          rd_dc1 = 0;
    int          rd_dc0 = 0;

    always #4 clk = ~clk;

    lcd_dma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .lcd_dc(lcd_dc), .lcd_wr(lcd_wr), .lcd_rd(lcd_rd),
        .lcd_dout(lcd_dout), .lcd_din(lcd_din), .irq(irq), .irq_prio(irq_prio),
        .bus_prio(bus_prio)
    );

    assign lcd_din = 16'hA000 + 16'(rd_cnt);

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (lcd_wr && wn < 64) begin
            wlog[wn] <= lcd_dout;
            wdc[wn]  <= lcd_dc;
            wn       <= wn + 1;
        end
        if (lcd_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (lcd_dc) rd_dc1 <= rd_dc1 + 1;
            else        rd_dc0 <= rd_dc0 + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_read(3'd2, v);
        check("R12 reset status", v, 8'h00);
        check("R12 reset strobes", {lcd_wr, lcd_rd, mem_rd, mem_wr}, 4'b0);
        check("R7 reset irq", irq, 1'b0);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        reg_write(3'd0, 8'h0E);
        reg_read(3'd0, v);
        check("R11 config readback", v, 8'h0E);
        check("R11 irq_prio pin", irq_prio, 2'b11);
        check("R11 bus_prio pin", bus_prio, 2'b01);
    endtask

    task automatic t_disabled();
        int w0 = wn;
        logic [7:0] v;
        reg_write(3'd1, 8'h1E);
        wait_cycles(6);
        reg_read(3'd2, v);
        check("R1 no start while disabled", v[2], 1'b0);
        check("R1 no strobes while disabled", wn - w0 + rd_cnt, 0);
    endtask

    task automatic t_zero_trig();
        logic [7:0] v;
        reg_write(3'd1, 8'h01);
        reg_read(3'd2, v);
        check("R3 zero triggers keep idle", v[2], 1'b0);
        reg_read(3'd1, v);
        check("R1 enable stored", v, 8'h01);
    endtask

    task automatic t_send_cmd();
        logic [7:0] v;
        int w0 = wn;
        for (int i = 0; i < 3; i++) mem[8'h10 + i] = 16'h1230 + 16'(i);
        reg_write(3'd3, 8'h10);
        reg_write(3'd4, 8'd2);
        reg_write(3'd1, 8'h03);
        reg_read(3'd2, v);
        check("R12 busy after trigger", v[2], 1'b1);
        wait_cycles(8);
        reg_read(3'd2, v);
        check("R4 still busy before 9th edge", v, 8'h04);
        wait_cycles(1);
        reg_read(3'd2, v);
        check("R6 done at 9th edge", v, 8'h01);
        check("R4 word count", wn - w0, 3);
        for (int i = 0; i < 3; i++) begin
            check("R4 send word order", wlog[w0 + i], 16'h1230 + 16'(i));
            check("R2 command select low", wdc[w0 + i], 1'b0);
        end
    endtask

    task automatic t_flags();
        logic [7:0] v;
        check("R7 irq off when disabled", irq, 1'b0);
        reg_write(3'd0, 8'h01);
        check("R7 irq on with enable", irq, 1'b1);
        reg_write(3'd2, 8'h03);
        reg_read(3'd2, v);
        check("R6 writing 1 keeps done", v[0], 1'b1);
        reg_write(3'd2, 8'h02);
        reg_read(3'd2, v);
        check("R6 writing 0 clears done", v[0], 1'b0);
        check("R7 irq follows clear", irq, 1'b0);
    endtask

    task automatic t_send_data_prio();
        logic [7:0] v;
        int w0 = wn;
        int r0 = rd_cnt;
        mem[8'h20] = 16'hBEEF;
        reg_write(3'd3, 8'h20);
        reg_write(3'd4, 8'd0);
        reg_write(3'd1, 8'h0D);
        wait_cycles(2);
        reg_read(3'd2, v);
        check("R4 single word busy before 3rd edge", v[2], 1'b1);
        wait_cycles(1);
        reg_read(3'd2, v);
        check("R4 single word done at 3rd edge", v, 8'h01);
        check("R2 lowest trigger wins", wn - w0, 1);
        check("R2 no read strobe", rd_cnt - r0, 0);
        check("R2 data select high", wdc[w0], 1'b1);
        check("R4 data word", wlog[w0], 16'hBEEF);
        reg_write(3'd2, 8'h02);
    endtask

    task automatic t_read();
        logic [7:0] v;
        int r0 = rd_cnt;
        int d1 = rd_dc1;
        int d0 = rd_dc0;
        reg_write(3'd3, 8'h40);
        reg_write(3'd4, 8'd3);
        reg_write(3'd1, 8'h11);
        wait_cycles(7);
        reg_read(3'd2, v);
        check("R5 busy before 8th edge", v[2], 1'b1);
        wait_cycles(1);
        reg_read(3'd2, v);
        check("R5 done at 8th edge", v, 8'h01);
        for (int i = 0; i < 4; i++)
            check("R5 stored word", mem[8'h40 + i], 16'hA000 + 16'(r0 + i));
        check("R2 read data select high", rd_dc1 - d1, 4);
        reg_write(3'd2, 8'h02);
        reg_write(3'd3, 8'h50);
        reg_write(3'd4, 8'd0);
        reg_write(3'd1, 8'h09);
        wait_cycles(3);
        check("R2 read command select low", rd_dc0 - d0, 1);
        check("R5 read command word", mem[8'h50], 16'hA000 + 16'(r0 + 4));
        reg_write(3'd2, 8'h02);
    endtask

    task automatic t_busy_trig();
        logic [7:0] v;
        int w0 = wn;
        int r0 = rd_cnt;
        reg_write(3'd3, 8'h10);
        reg_write(3'd4, 8'd2);
        reg_write(3'd1, 8'h05);
        reg_write(3'd1, 8'h11);
        wait_cycles(7);
        reg_read(3'd2, v);
        check("R10 original timing kept", v, 8'h01);
        check("R10 ignored trigger gives no read", rd_cnt - r0, 0);
        check("R10 word count unchanged", wn - w0, 3);
        reg_write(3'd2, 8'h02);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        int wa;
        reg_write(3'd3, 8'h10);
        reg_write(3'd4, 8'd3);
        reg_write(3'd1, 8'h05);
        wait_cycles(3);
        wa = wn;
        reg_write(3'd5, 8'h5A);
        reg_read(3'd2, v);
        check("R8 abort: idle, overwrite, no done", v, 8'h02);
        wait_cycles(12);
        check("R8 no strobe after abort", wn, wa);
        reg_read(3'd2, v);
        check("R8 done stays clear", v[0], 1'b0);
        reg_read(3'd5, v);
        check("R8 written byte stored", v, 8'h5A);
        reg_write(3'd2, 8'h03);
        reg_read(3'd2, v);
        check("R9 writing 1 keeps overwrite", v[1], 1'b1);
        reg_write(3'd2, 8'h01);
        reg_read(3'd2, v);
        check("R9 writing 0 clears overwrite", v[1], 1'b0);
        reg_write(3'd6, 8'hC3);
        reg_read(3'd2, v);
        check("R9 idle write sets nothing", v, 8'h00);
        reg_read(3'd6, v);
        check("R9 high byte readback", v, 8'hC3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        t_reset();
        t_prio();
        t_disabled();
        t_zero_trig();
        reg_write(3'd0, 8'h00);
        t_send_cmd();
        t_flags();
        reg_write(3'd0, 8'h00);
        t_send_data_prio();
        t_read();
        t_busy_trig();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule